// File: doc/BRIEF.md
# Split Header/Payload Packet Transmit Source

This block sits on the application side of a packet transmit link that carries a packet's header and its payload over two separate handshakes. A local command port hands it one packet at a time: a 128-bit header, a flag saying whether a payload follows, a payload length in dwords, and whether the header is three or four dwords long. The block writes the payload flag and the length into their fixed fields of the header. It raises a request with that header and holds both until the sink acknowledges. When the packet has a payload, the block then streams 64-bit beats from a local read port.

The payload side uses a framing line and a beat-valid line. It stalls on every cycle in which the sink asks for a wait state. The two phases may overlap: a beat can go out in the same cycle as the acknowledge when the header is three dwords long. A following packet may be taken in the very cycle in which the current one completes, so the request line can stay high from one packet to the next.

Top module: `pkt_tx_source`

## Requirements
- R1: A synchronous active-low reset drops `pkt_req`, `dat_frame` and `dat_valid` on the next clock edge, and afterwards `cmd_ready` is high.
- R2: `pkt_hdr` equals `cmd_desc` taken at acceptance, with bit 126 replaced by `cmd_has_data` and bits [105:96] replaced by `cmd_len`. `pkt_hdr` and `pkt_req` stay unchanged until the cycle in which `pkt_ack` is high.
- R3: When `pkt_ack` arrives and no payload remains, `cmd_ready` is high in that same cycle. A command taken then appears as the new `pkt_hdr` on the next cycle, and `pkt_req` stays high throughout.
- R4: For a packet with payload, `dat_frame` rises in the first cycle of `pkt_req`, and `dat_valid` rises one cycle later.
- R5: `dat_frame` is low in every cycle in which the last beat of a packet is presented. `dat_valid` stays high until that beat is transferred and then falls on the next cycle.
- R6: A beat is transferred only in a cycle with `dat_valid` high and `dat_wait` low. Otherwise `pay_addr` and `dat_beat` are held. `pay_addr` is the beat index within the packet, starting at 0.
- R7: No beat is transferred before the cycle of `pkt_ack`. In the cycle of `pkt_ack`, a beat is transferred only when `cmd_hdr4` was 0 (3-dword header); with `cmd_hdr4` equal to 1 that beat is presented again.
- R8: A packet carries ceil(`cmd_len`/2) beats, and a length of 0 stands for 1024 dwords, that is 512 beats.
- R9: A packet with `cmd_has_data` at 0 never raises `dat_frame` or `dat_valid`. The block is ready again in its acknowledge cycle.
- R10: `cmd_ready` is high only when the request is absent or acknowledged in the current cycle, and the payload is finished or its last beat transfers in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The command is taken this cycle |
| cmd_desc | input | 128 | Header template |
| cmd_has_data | input | 1 | The packet carries payload |
| cmd_len | input | 10 | Payload length in dwords (0 = 1024) |
| cmd_hdr4 | input | 1 | 1 = four-dword header, 0 = three-dword header |
| pkt_req | output | 1 | Header request |
| pkt_hdr | output | 128 | Header presented to the sink |
| pkt_ack | input | 1 | One-cycle header acknowledge from the sink |
| dat_frame | output | 1 | Payload framing |
| dat_valid | output | 1 | Payload beat valid |
| dat_beat | output | 64 | Payload beat |
| dat_wait | input | 1 | Wait state requested by the sink |
| pay_addr | output | 9 | Beat index on the local read port |
| pay_data | input | 64 | Read data for `pay_addr`, combinational |

## Verification
`cmd_ready` follows `pkt_ack` and `dat_wait` in the same cycle. The bench therefore drives those inputs at the falling edge and reads `cmd_ready` one time step later. `pkt_req`, `pkt_hdr`, `dat_frame`, `dat_valid` and `pay_addr` change one clock edge after the event that causes them: the first cycle of a packet falls on the edge after the command is taken, and the next beat index falls on the edge of a transfer. The bench keeps its own count of transferred beats and its own acknowledge state from R6 and R7. From those it forms the expected value of every output at each falling edge, before it drives the next cycle's inputs.

// File: rtl/pkt_tx_source.sv
module pkt_tx_source #(
  parameter int DESC_W      = 128,
  parameter int DATA_W      = 64,
  parameter int LEN_W       = 10,
  parameter int HASDATA_BIT = 126,
  parameter int LEN_LSB     = 96,
  localparam int DPB        = DATA_W / 32,
  localparam int MAX_DW     = 1 << LEN_W,
  localparam int MAX_BEATS  = MAX_DW / DPB,
  localparam int CNT_W      = $clog2(MAX_BEATS + 1),
  localparam int ADDR_W     = $clog2(MAX_BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DESC_W-1:0] cmd_desc,
  input  logic              cmd_has_data,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_hdr4,
  output logic              pkt_req,
  output logic [DESC_W-1:0] pkt_hdr,
  input  logic              pkt_ack,
  output logic              dat_frame,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_beat,
  input  logic              dat_wait,
  output logic [ADDR_W-1:0] pay_addr,
  input  logic [DATA_W-1:0] pay_data
);

  logic              req_q, busy_q, valid_q, acked_q, hdr4_q;
  logic [DESC_W-1:0] hdr_q, hdr_in;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] idx_q;

  function automatic logic [CNT_W-1:0] beats_of(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] dw;
    dw = (len == '0) ? (LEN_W+1)'(MAX_DW) : {1'b0, len};
    return CNT_W'((dw + (LEN_W+1)'(DPB - 1)) / (LEN_W+1)'(DPB));
  endfunction

  always_comb begin
    hdr_in = cmd_desc;
    hdr_in[HASDATA_BIT] = cmd_has_data;
    hdr_in[LEN_LSB +: LEN_W] = cmd_len;
  end

  wire ack_hit = req_q & pkt_ack;
  wire gate    = acked_q | (ack_hit & ~hdr4_q);
  wire xfer    = valid_q & ~dat_wait & gate;
  wire last    = xfer & (left_q == CNT_W'(1));
  wire take    = cmd_valid & cmd_ready;

  assign cmd_ready = (~req_q | pkt_ack) & (~busy_q | last);
  assign pkt_req   = req_q;
  assign pkt_hdr   = hdr_q;
  assign dat_valid = valid_q;
  assign dat_frame = busy_q & (~valid_q | (left_q > CNT_W'(1)));
  assign dat_beat  = pay_data;
  assign pay_addr  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      acked_q <= 1'b0;
      hdr4_q  <= 1'b0;
      hdr_q   <= '0;
      left_q  <= '0;
      idx_q   <= '0;
    end else if (take) begin
      req_q   <= 1'b1;
      hdr_q   <= hdr_in;
      hdr4_q  <= cmd_hdr4;
      acked_q <= 1'b0;
      busy_q  <= cmd_has_data;
      valid_q <= 1'b0;
      left_q  <= cmd_has_data ? beats_of(cmd_len) : '0;
      idx_q   <= '0;
    end else begin
      if (ack_hit) begin
        req_q   <= 1'b0;
        acked_q <= 1'b1;
      end
      if (busy_q) begin
        if (!valid_q) begin
          valid_q <= 1'b1;
        end else if (xfer) begin
          left_q <= left_q - CNT_W'(1);
          idx_q  <= idx_q + ADDR_W'(1);
          if (left_q == CNT_W'(1)) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pkt_tx_source_chk.sv
module pkt_tx_source_chk #(
  parameter int DESC_W      = 128,
  parameter int ADDR_W      = 9,
  parameter int HASDATA_BIT = 126
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_req,
  input logic [DESC_W-1:0] pkt_hdr,
  input logic              pkt_ack,
  input logic              dat_frame,
  input logic              dat_valid,
  input logic              dat_wait,
  input logic [ADDR_W-1:0] pay_addr
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> !pkt_req && !dat_frame && !dat_valid);

  // R2
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req && !pkt_ack |=> pkt_req && $stable(pkt_hdr));

  // R4
  frame_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_frame) |-> pkt_req && (!$past(pkt_req) || $past(pkt_ack)));

  // R4
  valid_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_valid) |-> $past(dat_frame));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && dat_wait |=> dat_valid && $stable(pay_addr));

  // R9
  nodata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req && !pkt_hdr[HASDATA_BIT] |-> !dat_frame && !dat_valid);

endmodule

bind pkt_tx_source pkt_tx_source_chk #(
  .DESC_W(DESC_W), .ADDR_W(ADDR_W), .HASDATA_BIT(HASDATA_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_req(pkt_req), .pkt_hdr(pkt_hdr),
  .pkt_ack(pkt_ack), .dat_frame(dat_frame), .dat_valid(dat_valid),
  .dat_wait(dat_wait), .pay_addr(pay_addr)
);

// File: tb/pkt_tx_source_test.sv
module pkt_tx_source_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0, cmd_ready;
  logic [127:0] cmd_desc = '0;
  logic         cmd_has_data = 1'b0;
  logic [9:0]   cmd_len = '0;
  logic         cmd_hdr4 = 1'b0;
  logic         pkt_req, pkt_ack = 1'b0;
  logic [127:0] pkt_hdr;
  logic         dat_frame, dat_valid, dat_wait = 1'b0;
  logic [63:0]  dat_beat, pay_data;
  logic [8:0]   pay_addr;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  function automatic logic [63:0] pat(input logic [8:0] a);
    return {8{8'h5A}} ^ {55'd0, a};
  endfunction
  assign pay_data = pat(pay_addr);

  pkt_tx_source uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_desc(cmd_desc), .cmd_has_data(cmd_has_data), .cmd_len(cmd_len),
    .cmd_hdr4(cmd_hdr4), .pkt_req(pkt_req), .pkt_hdr(pkt_hdr), .pkt_ack(pkt_ack),
    .dat_frame(dat_frame), .dat_valid(dat_valid), .dat_beat(dat_beat),
    .dat_wait(dat_wait), .pay_addr(pay_addr), .pay_data(pay_data)
  );

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [127:0] exp_hdr(input logic [127:0] d, input logic has, input logic [9:0] len);
    logic [127:0] e;
    e = d;
    e[126] = has;
    e[105:96] = len;
    return e;
  endfunction

  function automatic int nbeats(input logic [9:0] len);
    int dw;
    dw = (len == 0) ? 1024 : int'(len);
    return (dw + 1) / 2;
  endfunction

  // {has, hdr4, len[9:0], ack_delay[3:0], wait_mask[7:0]}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 1'b0, 10'd1,    4'd1, 8'h00},
    {1'b1, 1'b1, 10'd1,    4'd1, 8'h00},
    {1'b1, 1'b0, 10'd5,    4'd3, 8'h24},
    {1'b1, 1'b1, 10'd8,    4'd0, 8'hAA},
    {1'b0, 1'b0, 10'd7,    4'd2, 8'h00},
    {1'b1, 1'b0, 10'd0,    4'd1, 8'h80},
    {1'b1, 1'b0, 10'd2,    4'd5, 8'h00},
    {1'b1, 1'b1, 10'd1023, 4'd1, 8'h00}
  };

  task automatic run_vec(input logic [23:0] v, input int i);
    logic has, hdr4, acked, ack_now, ws, xv, gate, xfer, exp_frame, exp_ready;
    logic [9:0] len;
    logic [127:0] d, eh;
    int ackd, n, done, c;
    {has, hdr4, len} = v[23:12];
    ackd = int'(v[11:8]);
    n = has ? nbeats(len) : 0;
    d = {4{32'hC3A5_0F00 + i}};
    eh = exp_hdr(d, has, len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_desc = d; cmd_has_data = has; cmd_len = len; cmd_hdr4 = hdr4;
    #1 chk(cmd_ready == 1'b1, "R10 ready when idle", cmd_ready, 1);
    @(posedge clk);
    acked = 1'b0; done = 0; c = 0;
    while (!(acked && done == n)) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      ack_now = !acked && (c == ackd);
      ws = v[c % 8];
      pkt_ack = ack_now; dat_wait = ws;
      #1;
      xv = has && c >= 1 && done < n;
      exp_frame = has && done < n && (c == 0 || n - done > 1);
      chk(pkt_req == !acked, "R2 request held until ack", pkt_req, !acked);
      if (!acked) chk(pkt_hdr == eh, "R2 header fields", pkt_hdr, eh);
      chk(dat_frame == exp_frame, has ? "R5 framing" : "R9 no framing", dat_frame, exp_frame);
      chk(dat_valid == xv, has ? "R4 beat valid" : "R9 no valid", dat_valid, xv);
      if (xv) begin
        chk(pay_addr == 9'(done), "R6/R7 beat index", pay_addr, done);
        chk(dat_beat == pat(9'(done)), "R6 beat data", dat_beat, pat(9'(done)));
      end
      gate = acked || (ack_now && !hdr4);
      xfer = xv && !ws && gate;
      exp_ready = (acked || ack_now) && (done == n || (xfer && n - done == 1));
      chk(cmd_ready == exp_ready, "R10 ready", cmd_ready, exp_ready);
      @(posedge clk);
      if (xfer) done++;
      if (ack_now) acked = 1'b1;
      c++;
    end
    @(negedge clk);
    pkt_ack = 1'b0; dat_wait = 1'b0;
    #1;
    chk(!pkt_req && !dat_frame && !dat_valid, "R8 idle after all beats",
        {pkt_req, dat_frame, dat_valid}, 0);
    chk(cmd_ready == 1'b1, "R10 ready after packet", cmd_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [127:0] db;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1 chk(!pkt_req && !dat_frame && !dat_valid, "R1 reset outputs", {pkt_req, dat_frame, dat_valid}, 0);
    rst_n = 1'b1;
    #1 chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R3: no-payload packet, then a one-beat packet taken in its ack cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_desc = {4{32'h1111_2222}}; cmd_has_data = 1'b0; cmd_len = 10'd3; cmd_hdr4 = 1'b0;
    @(posedge clk);
    @(negedge clk);
    db = {4{32'h7777_0001}};
    cmd_desc = db; cmd_has_data = 1'b1; cmd_len = 10'd2; cmd_hdr4 = 1'b0; pkt_ack = 1'b1;
    #1 chk(cmd_ready == 1'b1, "R3 ready in ack cycle", cmd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; pkt_ack = 1'b0;
    #1;
    chk(pkt_req == 1'b1, "R3 request stays high", pkt_req, 1);
    chk(pkt_hdr == exp_hdr(db, 1'b1, 10'd2), "R3 next header", pkt_hdr, exp_hdr(db, 1'b1, 10'd2));
    chk(dat_frame == 1'b1 && dat_valid == 1'b0, "R4 frame before valid", {dat_frame, dat_valid}, 2'b10);
    chk(cmd_ready == 1'b0, "R10 busy not ready", cmd_ready, 0);
    @(posedge clk);
    @(negedge clk);
    pkt_ack = 1'b1;
    #1;
    chk(dat_valid == 1'b1 && dat_frame == 1'b0, "R5 single beat unframed", {dat_frame, dat_valid}, 2'b01);
    chk(cmd_ready == 1'b1, "R7 beat with ack on short header", cmd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    pkt_ack = 1'b0;
    #1 chk(!pkt_req && !dat_valid && !dat_frame, "R5 valid falls after last beat",
           {pkt_req, dat_frame, dat_valid}, 0);

    // R1: reset in the middle of a payload
    @(negedge clk);
    cmd_valid = 1'b1; cmd_has_data = 1'b1; cmd_len = 10'd20; cmd_hdr4 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; pkt_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_ack = 1'b0; rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1 chk(!pkt_req && !dat_frame && !dat_valid, "R1 mid-packet reset", {pkt_req, dat_frame, dat_valid}, 0);
    rst_n = 1'b1;
    #1 chk(cmd_ready == 1'b1, "R1 ready after mid reset", cmd_ready, 1);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule